// File: doc/BRIEF.md
# Least-Recently-Served Memory Arbiter with Per-Channel Hold Quotas

This block sits in front of a memory controller and chooses one of `N_CH` requesting channels each cycle (a processor core, disk, USB or network DMA engines and similar). The base ranking is least-recently-served: the channel whose last accepted grant lies furthest back wins. Each channel also carries a 4-bit hold quota that software may rewrite at any time. When a channel wins, it keeps the top slot for up to that many further accepted requests, and only then drops to the most-recently-served position. This sets aside a tunable slice of memory bandwidth for each channel.

The grant is one-hot and combinational. It stays unchanged while the memory controller withholds `accept` and the requests stay the same. The ranking and the hold counter move only on an accepted grant. The one exception is a channel that holds the top slot and withdraws its request: its hold is dropped at the next edge, so the ranking never stalls on an idle channel.

Top module: `qos_lru_arbiter`

## Requirements
- R1: `gnt` is one-hot or zero, has a bit set only where `req` is set, and is non-zero whenever any `req` bit is set.
- R2: When no hold is active, the grant goes to the requesting channel that was accepted least recently. An accepted channel that ends its hold, or that has no hold to begin with, moves to the most-recently-served position.
- R3: After reset the ranking runs from channel 0 (least recent) to channel `N_CH-1` (most recent), no hold is active, and every quota is 0.
- R4: With quota q on a channel, that channel receives q+1 consecutive accepted grants while it keeps requesting. Its hold then ends and it becomes most recent.
- R5: Quota 0 gives plain least-recently-served rotation, with a demotion after every accepted grant.
- R6: While `accept` is low and `req` is unchanged, `gnt` is unchanged. The ranking and the hold count change only on an accepted grant, or under R7.
- R7: If the holding channel drops its request, its hold ends at the next edge and it becomes most recent. The same cycle's grant goes to the least recent requester.
- R8: A quota write (`cfg_we`, channel `cfg_ch`, value `cfg_quota`, 4 bits) takes effect from the next clock edge. If the written quota is already at or below the running hold count, the holder is demoted on its next accepted grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_CH | Per-channel request |
| gnt | output | N_CH | One-hot grant |
| accept | input | 1 | Memory controller takes the granted request |
| cfg_we | input | 1 | Quota write strobe |
| cfg_ch | input | CH_W | Channel index for the quota write |
| cfg_quota | input | 4 | New quota value |

## Verification
The hardest case to reach is a quota that is lowered below a hold already in progress. The lowering has to land at the very moment a hold count exists. The bench programs a large quota, lets one channel collect several accepted grants, and then rewrites that channel's quota to a smaller value mid-hold. A second hard case is a holder withdrawing its request in the same cycle that another channel's grant is accepted. A long random phase with sparse quota writes and a sticky request pattern covers that case and the mixed orderings. Every cycle is compared against a queue-based ranking model.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  localparam int unsigned QUOTA_W = 4;
  typedef logic [QUOTA_W-1:0] quota_t;

  // A hold is spent once the count of extra grants has reached the quota.
  function automatic logic quota_spent(input quota_t used, input quota_t limit);
    return used >= limit;
  endfunction

  // Saturating-free increment of the hold count (quota is at most 15, so
  // the count never has to exceed 15 before demotion).
  function automatic quota_t hold_next(input quota_t used);
    return used + quota_t'(1);
  endfunction
endpackage

// File: rtl/qos_lru_order.sv
module qos_lru_order #(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req,
  input  logic            dem_a_vld,
  input  logic [CH_W-1:0] dem_a_id,
  input  logic            dem_b_vld,
  input  logic [CH_W-1:0] dem_b_id,
  output logic [N_CH-1:0] pick
);
  // older_q[i][j] = 1 : channel i was served before channel j (i ranks higher)
  logic [N_CH-1:0] older_q [N_CH];
  logic [N_CH-1:0] older_d [N_CH];

  genvar gi;
  generate
    for (gi = 0; gi < N_CH; gi++) begin : g_pick
      logic [N_CH-1:0] beaten;
      always_comb begin
        for (int j = 0; j < N_CH; j++) begin
          beaten[j] = (j != gi) && req[j] && older_q[j][gi];
        end
      end
      assign pick[gi] = req[gi] && (beaten == '0);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < N_CH; i++) older_d[i] = older_q[i];
    if (dem_a_vld) begin
      for (int j = 0; j < N_CH; j++) begin
        if (CH_W'(j) != dem_a_id) begin
          older_d[dem_a_id][j] = 1'b0;
          older_d[j][dem_a_id] = 1'b1;
        end
      end
    end
    if (dem_b_vld) begin
      for (int j = 0; j < N_CH; j++) begin
        if (CH_W'(j) != dem_b_id) begin
          older_d[dem_b_id][j] = 1'b0;
          older_d[j][dem_b_id] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) begin
        for (int j = 0; j < N_CH; j++) older_q[i][j] <= (i < j);
      end
    end else begin
      for (int i = 0; i < N_CH; i++) older_q[i] <= older_d[i];
    end
  end
endmodule

// File: rtl/qos_hold_ctrl.sv
module qos_hold_ctrl
  import qos_arb_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CH_W-1:0] cfg_ch,
  input  quota_t          cfg_quota,
  input  logic [N_CH-1:0] req,
  input  logic            fire,
  input  logic [CH_W-1:0] win_id,
  output logic            hold_vld,
  output logic [CH_W-1:0] hold_id,
  output logic            abandon,
  output logic            demote_win
);
  quota_t          quota_q [N_CH];
  quota_t          used_q;
  logic            same_hold;
  quota_t          used_base;

  assign abandon    = hold_vld && !req[hold_id];
  assign same_hold  = hold_vld && !abandon && (hold_id == win_id);
  assign used_base  = same_hold ? used_q : '0;
  assign demote_win = fire && quota_spent(used_base, quota_q[win_id]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) quota_q[i] <= '0;
    end else if (cfg_we && (int'(cfg_ch) < N_CH)) begin
      quota_q[cfg_ch] <= cfg_quota;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_id  <= '0;
      used_q   <= '0;
    end else if (fire) begin
      if (demote_win) begin
        hold_vld <= 1'b0;
        used_q   <= '0;
      end else begin
        hold_vld <= 1'b1;
        hold_id  <= win_id;
        used_q   <= hold_next(used_base);
      end
    end else if (abandon) begin
      hold_vld <= 1'b0;
      used_q   <= '0;
    end
  end
endmodule

// File: rtl/qos_lru_arbiter.sv
module qos_lru_arbiter
  import qos_arb_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   req,
  output logic [N_CH-1:0]   gnt,
  input  logic              accept,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [QUOTA_W-1:0] cfg_quota
);
  logic [N_CH-1:0] lru_pick;
  logic            hold_vld;
  logic [CH_W-1:0] hold_id;
  logic            abandon;
  logic            demote_win;
  logic            fire;
  logic            hold_live;
  logic [CH_W-1:0] win_id;

  assign hold_live = hold_vld && req[hold_id];
  assign gnt  = hold_live ? (N_CH'(1) << hold_id) : lru_pick;
  assign fire = accept && (gnt != '0);

  always_comb begin
    win_id = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (gnt[i]) win_id = CH_W'(i);
    end
  end

  qos_lru_order #(.N_CH(N_CH)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .dem_a_vld (abandon),
    .dem_a_id  (hold_id),
    .dem_b_vld (demote_win),
    .dem_b_id  (win_id),
    .pick      (lru_pick)
  );

  qos_hold_ctrl #(.N_CH(N_CH)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_ch     (cfg_ch),
    .cfg_quota  (cfg_quota),
    .req        (req),
    .fire       (fire),
    .win_id     (win_id),
    .hold_vld   (hold_vld),
    .hold_id    (hold_id),
    .abandon    (abandon),
    .demote_win (demote_win)
  );
endmodule

// File: rtl/qos_lru_arbiter_chk.sv
module qos_lru_arbiter_chk #(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] req,
  input logic [N_CH-1:0] gnt,
  input logic            accept,
  input logic            hold_vld,
  input logic [CH_W-1:0] hold_id,
  input logic            abandon
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_only_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_some_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (gnt != '0));
  p_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && !accept) |=> ($stable(req) |-> $stable(gnt)));
  p_hold_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && req[hold_id]) |-> gnt[hold_id]);
  p_abandon_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abandon && !accept) |=> !hold_vld);
  p_reset_r3: assert property (@(posedge clk)
    !rst_n |=> !hold_vld);
endmodule

bind qos_lru_arbiter qos_lru_arbiter_chk #(.N_CH(N_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .gnt      (gnt),
  .accept   (accept),
  .hold_vld (hold_vld),
  .hold_id  (hold_id),
  .abandon  (abandon)
);

// File: tb/qos_lru_arbiter_tb.sv
`timescale 1ns/1ps
module qos_lru_arbiter_tb;
  localparam int N = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  gnt;
  logic          accept = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_ch = '0;
  logic [3:0]    cfg_quota = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model: order[0] is least recently served
  int order[$];
  int quota[N];
  int used;
  int holder;

  always #10 clk = ~clk;

  qos_lru_arbiter #(.N_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .accept(accept),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_quota(cfg_quota)
  );

  task automatic model_reset();
    order.delete();
    for (int i = 0; i < N; i++) begin
      order.push_back(i);
      quota[i] = 0;
    end
    used = 0;
    holder = -1;
  endtask

  task automatic to_back(input int ch);
    for (int k = 0; k < order.size(); k++) begin
      if (order[k] == ch) begin
        order.delete(k);
        break;
      end
    end
    order.push_back(ch);
  endtask

  function automatic int model_winner();
    if (holder >= 0 && req[holder]) return holder;
    foreach (order[k]) if (req[order[k]]) return order[k];
    return -1;
  endfunction

  task automatic model_edge();
    int w;
    int base;
    w = model_winner();
    if (holder >= 0 && !req[holder]) begin
      to_back(holder);
      holder = -1;
      used = 0;
    end
    if (accept && w >= 0) begin
      base = (holder == w) ? used : 0;
      if (base >= quota[w]) begin
        to_back(w);
        holder = -1;
        used = 0;
      end else begin
        holder = w;
        used = base + 1;
      end
    end
    if (cfg_we) quota[cfg_ch] = cfg_quota;
  endtask

  task automatic check(input logic [N-1:0] exp, input string tag);
    checks++;
    if (gnt !== exp) begin
      errors++;
      $display("FAIL %s: gnt actual=%b expected=%b at %0t", tag, gnt, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic a, input string tag,
                      input logic we = 1'b0, input int ch = 0, input int q = 0);
    int w;
    @(negedge clk);
    req = r; accept = a; cfg_we = we; cfg_ch = CW'(ch); cfg_quota = 4'(q);
    #5;
    w = model_winner();
    check((w >= 0) ? N'(1) << w : '0, tag);
    model_edge();
  endtask

  task automatic setq(input int ch, input int q);
    step('0, 1'b0, "R8 write", 1'b1, ch, q);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R3 reset state: idle then order 0 first
    step('0, 1'b0, "R3 idle");
    step('1, 1'b0, "R3 reset order");
    check(4'b0001, "R3 channel0 least recent");
    // R5 / R2 plain rotation with all quotas 0
    for (int i = 0; i < 8; i++) step('1, 1'b1, "R5 rotation");
    step(4'b1010, 1'b1, "R2 subset");
    step(4'b1010, 1'b1, "R2 subset");
    // R6 no accept: stable grant
    for (int i = 0; i < 4; i++) step(4'b0111, 1'b0, "R6 stall");
    // R4 quota 2 on channel 1: three consecutive grants
    setq(1, 2);
    for (int i = 0; i < 5; i++) step(4'b0110, 1'b1, "R4 quota2");
    // R4 maximum quota 15: sixteen grants
    setq(3, 15);
    for (int i = 0; i < 18; i++) step(4'b1001, 1'b1, "R4 quota15");
    // R7 holder withdraws
    setq(0, 5);
    step(4'b0101, 1'b1, "R7 hold start");
    step(4'b0101, 1'b1, "R7 hold");
    step(4'b0100, 1'b0, "R7 withdraw");
    step(4'b0101, 1'b0, "R7 after withdraw");
    step(4'b0101, 1'b1, "R7 after withdraw");
    // R8 lower quota mid-hold
    setq(2, 9);
    step(4'b0110, 1'b1, "R8 build hold");
    step(4'b0110, 1'b1, "R8 build hold");
    step(4'b0110, 1'b1, "R8 build hold");
    step(4'b0110, 1'b1, "R8 lower", 1'b1, 2, 1);
    step(4'b0110, 1'b1, "R8 demote on next grant");
    step(4'b0110, 1'b1, "R8 next winner");
    // R1 random mix with sparse quota writes and sticky requests
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      r = ($urandom_range(0, 3) == 0) ? N'($urandom) : req;
      step(r, 1'($urandom), "R1 random",
           ($urandom_range(0, 15) == 0), $urandom_range(0, N - 1),
           $urandom_range(0, 4));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule